// File: doc/BRIEF.md
# Configurable Programmable-Logic I/O Macrocell

This block is one input/output cell of a programmable logic device, built as ordinary synchronous logic and steered by a static nine-bit configuration word. It takes the sum-of-products result from the logic array and the value on its pin. It can pass either one straight through, or hold it in a storage element that acts as an edge-triggered register or as a transparent latch. It then returns values to the array as feedback, and it produces the pin drive value and the pin's tri-state enable.

The two clock/latch-enable sources are treated as data. They are sampled by the system clock `clk_i`. A "rising edge" of the selected source is the first system-clock cycle in which its phase-adjusted value is sampled high after being sampled low. The common clear and preset act on the stored value asynchronously. One parameter picks the feedback variant. The dual variant shows pin and storage node side by side. The single variant muxes the two onto one line.

Top module: `mc_io_cell`

## Requirements
- R1: Configuration bit encoding (bit 0 = LSB): [0] bypass (1 combinational, 0 stored), [1] polarity (1 drive true, 0 drive inverted), [2] element kind (1 edge register, 0 level latch), [3] direction (1 array sum feeds the node and the pin is driven from it, 0 pin feeds the node), [5:4] enable source, [7:6] output-enable mode, [8] single-feedback mux. The all-ones word gives combinational, true-polarity output with the enable pin in control.
- R2: With polarity bit 0 the pin drive value is the inverse of the value it carries with polarity bit 1.
- R3: In register mode the stored value loads the data source on the system-clock edge at which the selected phase is sampled high after having been sampled low, and holds at every other edge. After reset a source already high produces no load.
- R4: In latch mode the node follows the data source combinationally while the selected phase is high, and holds the last value while it is low.
- R5: Enable source encoding [5:4]: 11 main source true, 10 main source inverted, 01 shared source true, 00 shared source inverted. The unselected source has no effect.
- R6: In input direction the pin value is the data source, and the drive value is the array sum after polarity.
- R7: Output-enable mode [7:6]: 11 follows the enable pin, 10 is the XOR of the bank's product terms, 01 is always on, 00 is always off.
- R8: Clear forces the stored value to 0 and preset forces it to 1 without any clock edge. Clear wins when both are high. The reset input clears the stored value.
- R9: Dual-feedback variant: feedback 0 is always the pin value and feedback 1 is always the node value, so the element can hold buried state while the pin is an input.
- R10: Single-feedback variant: feedback 0 is the pin value when bit [8] is 1 and the node value when it is 0; feedback 1 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the enable sources |
| rst_ni | input | 1 | Active-low reset |
| cfg_i | input | 9 | Static configuration word |
| sum_i | input | 1 | Sum-of-products term from the array |
| pin_i | input | 1 | Value seen on the pin |
| ck_main_i | input | 1 | Dedicated clock/latch-enable source |
| ck_alt_i | input | 1 | Shared input/clock/latch-enable source |
| oe_pin_i | input | 1 | Common output-enable pin |
| oe_pt_i | input | NPT | Bank output-enable product terms |
| preset_i | input | 1 | Common asynchronous preset |
| clear_i | input | 1 | Common asynchronous clear |
| drive_o | output | 1 | Value driven onto the pin |
| oe_o | output | 1 | Tri-state enable for the pin |
| fb0_o | output | 1 | First feedback line to the array |
| fb1_o | output | 1 | Second feedback line (0 in the single variant) |

## Verification
Output enable, combinational paths, latch transparency, clear and preset all reach the outputs within the same cycle as their stimulus. A register load appears only after the system-clock edge at which the sampled phase is seen to rise. The bench changes inputs on the falling clock edge and updates its reference model from the values present at the following rising edge. It then compares all outputs at the next falling edge, so each result is read one half-cycle after the edge that produced it.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        OE_OFF = 2'b00,
        OE_ON  = 2'b01,
        OE_PT  = 2'b10,
        OE_PIN = 2'b11
    } oe_mode_e;

    typedef enum logic [1:0] {
        CK_ALT_N  = 2'b00,
        CK_ALT    = 2'b01,
        CK_MAIN_N = 2'b10,
        CK_MAIN   = 2'b11
    } ck_sel_e;

    typedef struct packed {
        logic     fb_pin;
        oe_mode_e oe_mode;
        ck_sel_e  ck_sel;
        logic     dir_out;
        logic     kind_reg;
        logic     pol_high;
        logic     bypass;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/mc_ck_sel.sv
module mc_ck_sel (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ck_main_i,
    input  logic       ck_alt_i,
    input  logic [1:0] sel_i,
    output logic       phase_o,
    output logic       rise_o
);
    typedef struct packed {
        logic hist;
    } hist_t;

    hist_t st_d, st_q;
    logic  raw;

    always_comb begin
        raw     = sel_i[1] ? ck_main_i : ck_alt_i;
        phase_o = sel_i[0] ? raw : ~raw;
        rise_o  = phase_o & ~st_q.hist;
        st_d    = st_q;
        st_d.hist = phase_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{hist: 1'b1};
        else         st_q <= st_d;
    end
endmodule

// File: rtl/mc_store.sv
module mc_store (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic preset_i,
    input  logic kind_reg_i,
    input  logic phase_i,
    input  logic rise_i,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic val;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kind_reg_i) begin
            if (rise_i) st_d.val = d_i;
        end else if (phase_i) begin
            st_d.val = d_i;
        end
        if (clear_i)                       q_o = 1'b0;
        else if (preset_i)                 q_o = 1'b1;
        else if (!kind_reg_i && phase_i)   q_o = d_i;
        else                               q_o = st_q.val;
    end

    always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i or posedge preset_i) begin
        if (!rst_ni)       st_q <= '{val: 1'b0};
        else if (clear_i)  st_q <= '{val: 1'b0};
        else if (preset_i) st_q <= '{val: 1'b1};
        else               st_q <= st_d;
    end
endmodule

// File: rtl/mc_oe.sv
module mc_oe #(
    parameter int NPT = 2
) (
    input  mc_pkg::oe_mode_e mode_i,
    input  logic             pin_i,
    input  logic [NPT-1:0]   pt_i,
    output logic             oe_o
);
    always_comb begin
        unique case (mode_i)
            mc_pkg::OE_PIN: oe_o = pin_i;
            mc_pkg::OE_PT:  oe_o = ^pt_i;
            mc_pkg::OE_ON:  oe_o = 1'b1;
            default:        oe_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/mc_io_cell.sv
module mc_io_cell #(
    parameter bit DUAL_FB = 1'b1,
    parameter int NPT     = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [mc_pkg::CFG_W-1:0] cfg_i,
    input  logic                     sum_i,
    input  logic                     pin_i,
    input  logic                     ck_main_i,
    input  logic                     ck_alt_i,
    input  logic                     oe_pin_i,
    input  logic [NPT-1:0]           oe_pt_i,
    input  logic                     preset_i,
    input  logic                     clear_i,
    output logic                     drive_o,
    output logic                     oe_o,
    output logic                     fb0_o,
    output logic                     fb1_o
);
    mc_pkg::cfg_t cfg;
    logic phase, rise, src, stored, node, pre_pol;

    assign cfg = mc_pkg::cfg_t'(cfg_i);

    mc_ck_sel i_ck_sel (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ck_main_i (ck_main_i),
        .ck_alt_i  (ck_alt_i),
        .sel_i     (cfg.ck_sel),
        .phase_o   (phase),
        .rise_o    (rise)
    );

    mc_store i_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (clear_i),
        .preset_i   (preset_i),
        .kind_reg_i (cfg.kind_reg),
        .phase_i    (phase),
        .rise_i     (rise),
        .d_i        (src),
        .q_o        (stored)
    );

    mc_oe #(.NPT(NPT)) i_oe (
        .mode_i (cfg.oe_mode),
        .pin_i  (oe_pin_i),
        .pt_i   (oe_pt_i),
        .oe_o   (oe_o)
    );

    always_comb begin
        src     = cfg.dir_out ? sum_i : pin_i;
        node    = cfg.bypass ? src : stored;
        pre_pol = cfg.dir_out ? node : sum_i;
        drive_o = cfg.pol_high ? pre_pol : ~pre_pol;
    end

    generate
        if (DUAL_FB) begin : g_dual
            logic unused_fb_sel;
            assign unused_fb_sel = cfg.fb_pin;
            assign fb0_o = pin_i;
            assign fb1_o = node;
        end else begin : g_single
            assign fb0_o = cfg.fb_pin ? pin_i : node;
            assign fb1_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mc_io_cell_chk.sv
module mc_io_cell_chk #(
    parameter int NPT = 2
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [mc_pkg::CFG_W-1:0] cfg_i,
    input logic                     ck_main_i,
    input logic                     ck_alt_i,
    input logic [NPT-1:0]           oe_pt_i,
    input logic                     preset_i,
    input logic                     clear_i,
    input logic                     drive_o,
    input logic                     oe_o
);
    mc_pkg::cfg_t c;
    assign c = mc_pkg::cfg_t'(cfg_i);

    AST_OE_ALWAYS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c.oe_mode == mc_pkg::OE_ON) |-> oe_o);  // R7
    AST_OE_ALWAYS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c.oe_mode == mc_pkg::OE_OFF) |-> !oe_o);  // R7
    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clear_i && !c.bypass && c.dir_out) |-> (drive_o == !c.pol_high));  // R8
    AST_PRESET_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preset_i && !clear_i && !c.bypass && c.dir_out) |-> (drive_o == c.pol_high));  // R8
    AST_REG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c.kind_reg && !c.bypass && c.dir_out && !clear_i && !preset_i &&
         $stable(ck_main_i) && $stable(ck_alt_i) && $stable(cfg_i))
        |=> ($stable(drive_o) || clear_i || preset_i || !$stable(cfg_i)));  // R3
endmodule

bind mc_io_cell mc_io_cell_chk #(.NPT(NPT)) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_i),
    .ck_main_i (ck_main_i),
    .ck_alt_i  (ck_alt_i),
    .oe_pt_i   (oe_pt_i),
    .preset_i  (preset_i),
    .clear_i   (clear_i),
    .drive_o   (drive_o),
    .oe_o      (oe_o)
);

// File: tb/test_mc_io_cell.sv
`timescale 1ns/1ps
module test_mc_io_cell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] cfg = 9'b1_11_11_1_1_1_0;
    logic       sum = 1'b0, pin = 1'b0, ckm = 1'b0, cka = 1'b0, oep = 1'b0;
    logic [1:0] pt = 2'b00;
    logic       pre = 1'b0, clr = 1'b0;
    logic       drv_d, oe_d, f0_d, f1_d, drv_s, oe_s, f0_s, f1_s;
    int         n_chk = 0, n_fail = 0;
    bit         m_st = 1'b0, m_hist = 1'b1;

    always #5 clk = ~clk;

    mc_io_cell #(.DUAL_FB(1'b1), .NPT(2)) i_mc_io_cell (
        .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .sum_i(sum), .pin_i(pin),
        .ck_main_i(ckm), .ck_alt_i(cka), .oe_pin_i(oep), .oe_pt_i(pt),
        .preset_i(pre), .clear_i(clr),
        .drive_o(drv_d), .oe_o(oe_d), .fb0_o(f0_d), .fb1_o(f1_d));

    mc_io_cell #(.DUAL_FB(1'b0), .NPT(2)) i_mc_io_cell_single (
        .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .sum_i(sum), .pin_i(pin),
        .ck_main_i(ckm), .ck_alt_i(cka), .oe_pin_i(oep), .oe_pt_i(pt),
        .preset_i(pre), .clear_i(clr),
        .drive_o(drv_s), .oe_o(oe_s), .fb0_o(f0_s), .fb1_o(f1_s));

    function automatic bit phase_of();
        bit raw = cfg[5] ? ckm : cka;
        return cfg[4] ? raw : ~raw;
    endfunction

    function automatic bit src_of();
        return cfg[3] ? sum : pin;
    endfunction

    function automatic bit node_of();
        bit s = src_of();
        if (cfg[0])                  return s;
        if (clr)                     return 1'b0;
        if (pre)                     return 1'b1;
        if (!cfg[2] && phase_of())   return s;
        return m_st;
    endfunction

    function automatic bit drive_of();
        bit v = cfg[3] ? node_of() : sum;
        return cfg[1] ? v : ~v;
    endfunction

    function automatic bit oe_of();
        case (cfg[7:6])
            2'b11:   return oep;
            2'b10:   return pt[0] ^ pt[1];
            2'b01:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b cfg=%b t=%0t", tag, act, exp, cfg, $time);
        end
    endtask

    task automatic model_update();
        bit p = phase_of();
        bit d = src_of();
        if (clr)          m_st = 1'b0;
        else if (pre)     m_st = 1'b1;
        else if (cfg[2])  begin if (p && !m_hist) m_st = d; end
        else if (p)       m_st = d;
        m_hist = p;
    endtask

    task automatic check_all();
        string tag = cfg[0] ? (cfg[1] ? "R1" : "R2") :
                     (!cfg[3] ? "R6" : (clr || pre) ? "R8" : cfg[2] ? "R3" : "R4");
        chk(tag,  drv_d, drive_of());
        chk(tag,  drv_s, drive_of());
        chk("R7", oe_d,  oe_of());
        chk("R7", oe_s,  oe_of());
        chk("R9", f0_d,  pin);
        chk("R9", f1_d,  node_of());
        chk("R10", f0_s, cfg[8] ? pin : node_of());
        chk("R10", f1_s, 1'b0);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_all();
    endtask

    task automatic set_phase(logic [1:0] cs, bit v);
        bit raw = cs[0] ? v : ~v;
        if (cs[1]) ckm = raw; else cka = raw;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        ckm = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", drv_d, 1'b0);   // reset clears the stored value
        chk("R7", oe_d, 1'b0);
        rst_n = 1'b1;
        sum = 1'b1;
        cyc();
        chk("R3", drv_d, 1'b0);   // source already high after reset: no load

        // R1 default configuration
        cfg = 9'h1FF;
        for (int i = 0; i < 8; i++) begin
            sum = i[0]; pin = i[1]; oep = i[2];
            cyc();
            chk("R1", drv_d, sum);
            chk("R1", oe_d, oep);
            chk("R10", f0_s, pin);
        end

        // R5 / R3 / R4 clock source and element kind matrix
        for (int cs = 0; cs < 4; cs++) begin
            for (int k = 0; k < 2; k++) begin
                cfg = {1'b0, 2'b01, cs[1:0], 1'b1, k[0], 1'b1, 1'b0};
                sum = 1'b0; set_phase(cs[1:0], 1'b0); cyc();
                set_phase(cs[1:0], 1'b1); cyc();
                set_phase(cs[1:0], 1'b0); cyc();
                sum = 1'b1;
                if (cs[1]) cka = ~cka; else ckm = ~ckm;
                cyc();
                chk("R5", drv_d, 1'b0);
                set_phase(cs[1:0], 1'b1); cyc();
                chk("R5", drv_d, 1'b1);
                sum = 1'b0; cyc();
                chk(k ? "R3" : "R4", drv_d, k ? 1'b1 : 1'b0);
                set_phase(cs[1:0], 1'b0); sum = 1'b1; cyc();
                chk(k ? "R3" : "R4", drv_d, k ? 1'b1 : 1'b0);
            end
        end

        // R7 every output-enable mode
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 8; v++) begin
                cfg = {1'b1, m[1:0], 2'b11, 4'b1111};
                oep = v[0]; pt = v[2:1];
                cyc();
                chk("R7", oe_d, m == 3 ? v[0] : m == 2 ? v[1] ^ v[2] : m == 1);
            end
        end

        // R8 clear beats preset, both without a clock edge
        cfg = 9'b0_01_11_1_1_1_0;
        @(negedge clk); pre = 1'b1; #1; chk("R8", drv_d, 1'b1);
        clr = 1'b1; #1; chk("R8", drv_d, 1'b0);
        cyc();
        clr = 1'b0; cyc(); chk("R8", drv_d, 1'b1);
        pre = 1'b0; cyc();

        // R6 / R9 buried register while the pin is an input
        cfg = 9'b0_00_11_0_1_1_0;
        ckm = 1'b0; pin = 1'b1; sum = 1'b0; cyc();
        ckm = 1'b1; cyc();
        chk("R9", f1_d, 1'b1);
        pin = 1'b0; cyc();
        chk("R9", f0_d, 1'b0); chk("R9", f1_d, 1'b1); chk("R6", drv_d, 1'b0);
        cfg[1] = 1'b0; cyc(); chk("R2", drv_d, 1'b1);
        cfg[8] = 1'b0; cyc(); chk("R10", f0_s, 1'b1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) cfg = 9'($urandom);
            sum = 1'($urandom); pin = 1'($urandom);
            if ($urandom_range(2) == 0) ckm = ~ckm;
            if ($urandom_range(2) == 0) cka = ~cka;
            oep = 1'($urandom); pt = 2'($urandom);
            clr = ($urandom_range(15) == 0);
            pre = ($urandom_range(11) == 0);
            cyc();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule